// File: doc/BRIEF.md
# Configurable sum-of-products arithmetic unit

A purely combinational arithmetic block that forms one total from a variable number of terms. The number of terms, each operand's width, each term's signedness and each term's sign (add or subtract) come from a packed configuration bit-string parameter. All operands arrive on one concatenated input bus. A second, narrow input vector carries single-bit values that are each added to the total, as carry-in style increments.

The configuration starts with a 4-bit header, least significant bit first. The header gives the field width N that every later size field uses. Term descriptors follow one after another. Each descriptor holds, from its lowest bit upward:
- a signedness flag,
- a subtract flag,
- an N-bit size for operand A,
- an N-bit size for operand B.

Operand slices are cut from the input bus starting at bit 0, with A before B for each term. The configuration is decoded when the design is elaborated. A configuration whose length is not a whole number of descriptors, or whose slices do not use up the bus exactly, stops elaboration with an error.

Top module: `sop_unit`

## Requirements
- R1: The header, configuration bits [3:0] read as an unsigned number with bit 0 least significant, sets the width N of every size field. Each descriptor is 2+2N bits wide: bit 0 is the signedness flag, bit 1 is the subtract flag, bits [2+:N] are the A size and bits [2+N+:N] are the B size. Both sizes are read least significant bit first.
- R2: Operand slices are taken back to back from the operand bus, starting at bit 0, in descriptor order. A term's B slice starts at the bit just above its A slice.
- R3: A term whose B size is zero contributes its A operand alone. Any other term contributes the product A×B.
- R4: When a term's signedness flag is 1, both of its operands and the product are sign-extended to the result width. When the flag is 0, they are zero-extended.
- R5: A term whose subtract flag is 1 is taken away from the total. A term whose subtract flag is 0 is added to it.
- R6: Every bit of the single-bit input vector adds 0 or 1, as an unsigned value, to the total.
- R7: The total starts at zero and all arithmetic wraps modulo 2^OUT_W. With all inputs zero, the result is zero.
- R8: A descriptor whose A size and B size are both zero uses no bus bits and contributes nothing to the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | IN_W | Concatenated operand slices, first term at bit 0 |
| bits_i | input | BIT_W | Single-bit values, each added as 0 or 1 |
| result_o | output | OUT_W | Wrapped sum of all terms and single bits |

## Verification
Two instances with different header widths check that descriptor decoding and slice placement follow N. A bench that hard-coded one layout would misplace every operand under the second configuration. Directed vectors set the sign bit of each signed operand and the top bit of each unsigned operand. A design that mixed up sign extension and zero extension would then be off by a multiple of a power of two. Subtracted single operands and all-ones inputs check the negation path and the product path. Overflowing products and the all-ones single-bit vector check that the result wraps and that each single bit counts as exactly one. A descriptor with both sizes zero sits between two live terms. If it took bus bits or added a value, every later operand would shift and the random comparisons would fail.

// File: rtl/sop_cfg_pkg.sv
package sop_cfg_pkg;
  localparam int CFG_MAX_W = 512;
  localparam int HDR_W     = 4;

  typedef logic [CFG_MAX_W-1:0] cfg_vec_t;

  function automatic int read_field(cfg_vec_t c, int pos, int n);
    int v = 0;
    for (int i = 0; i < n; i++)
      if (c[pos+i]) v = v | (1 << i);
    return v;
  endfunction

  function automatic int field_w(cfg_vec_t c);
    return read_field(c, 0, HDR_W);
  endfunction

  function automatic int desc_w(cfg_vec_t c);
    return 2 + 2 * field_w(c);
  endfunction

  function automatic int term_count(cfg_vec_t c, int cw);
    return (cw - HDR_W) / desc_w(c);
  endfunction

  function automatic int desc_base(cfg_vec_t c, int k);
    return HDR_W + k * desc_w(c);
  endfunction

  function automatic bit term_signed(cfg_vec_t c, int k);
    return c[desc_base(c, k)];
  endfunction

  function automatic bit term_sub(cfg_vec_t c, int k);
    return c[desc_base(c, k) + 1];
  endfunction

  function automatic int term_size_a(cfg_vec_t c, int k);
    return read_field(c, desc_base(c, k) + 2, field_w(c));
  endfunction

  function automatic int term_size_b(cfg_vec_t c, int k);
    return read_field(c, desc_base(c, k) + 2 + field_w(c), field_w(c));
  endfunction

  function automatic int term_off(cfg_vec_t c, int k);
    int off = 0;
    for (int j = 0; j < k; j++)
      off = off + term_size_a(c, j) + term_size_b(c, j);
    return off;
  endfunction

  function automatic int bus_used(cfg_vec_t c, int cw);
    return term_off(c, term_count(c, cw));
  endfunction
endpackage

// File: rtl/sop_term.sv
module sop_term #(
  parameter int OUT_W     = 12,
  parameter int SA        = 8,
  parameter int SB        = 8,
  parameter bit IS_SIGNED = 1'b0,
  parameter bit DO_SUB    = 1'b0,
  localparam int AW = (SA > 0) ? SA : 1,
  localparam int BW = (SB > 0) ? SB : 1,
  localparam int WM = (AW > BW) ? AW : BW
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [OUT_W-1:0] raw_o,
  output logic [OUT_W-1:0] term_o
);
  // Extend an n-bit value to the result width: sign or zero fill by flag.
  function automatic logic [OUT_W-1:0] widen(logic [WM-1:0] v, int n);
    logic [OUT_W-1:0] r;
    r = '0;
    if (n > 0) begin
      for (int i = 0; i < OUT_W; i++)
        r[i] = (i < n) ? v[i] : (IS_SIGNED ? v[n-1] : 1'b0);
    end
    return r;
  endfunction

  logic [OUT_W-1:0] ext_a, ext_b;

  always_comb begin
    ext_a = widen(WM'(a_i), SA);
    ext_b = widen(WM'(b_i), SB);
  end

  if (SB == 0) begin : g_single
    assign raw_o = ext_a;
  end else begin : g_prod
    assign raw_o = ext_a * ext_b;
  end

  if (DO_SUB) begin : g_neg
    assign term_o = '0 - raw_o;
  end else begin : g_pos
    assign term_o = raw_o;
  end
endmodule

// File: rtl/sop_bitcount.sv
module sop_bitcount #(
  parameter int BIT_W = 3,
  parameter int CNT_W = 2
) (
  input  logic [BIT_W-1:0] bits_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < BIT_W; i++)
      cnt_o = cnt_o + CNT_W'(bits_i[i]);
  end
endmodule

// File: rtl/sop_accum.sv
module sop_accum #(
  parameter int NT    = 1,
  parameter int OUT_W = 12,
  parameter int CNT_W = 2
) (
  input  logic [NT-1:0][OUT_W-1:0] term_i,
  input  logic [CNT_W-1:0]         cnt_i,
  output logic [OUT_W-1:0]         sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NT; k++)
      sum_o = sum_o + term_i[k];
    sum_o = sum_o + OUT_W'(cnt_i);
  end
endmodule

// File: rtl/sop_unit.sv
module sop_unit #(
  parameter int CFG_W = 54,
  parameter logic [CFG_W-1:0] CFG = {10'd20, 10'd0, 10'd31, 10'd346, 10'd545, 4'd4},
  parameter int IN_W  = 39,
  parameter int BIT_W = 3,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0]  opnd_i,
  input  logic [BIT_W-1:0] bits_i,
  output logic [OUT_W-1:0] result_o
);
  import sop_cfg_pkg::*;

  localparam cfg_vec_t CFG_X  = cfg_vec_t'(CFG);
  localparam int       DW     = desc_w(CFG_X);
  localparam int       NT     = term_count(CFG_X, CFG_W);
  localparam int       NT_ARR = (NT > 0) ? NT : 1;
  localparam int       USED   = bus_used(CFG_X, CFG_W);
  localparam int       CNT_W  = $clog2(BIT_W + 1);

  if (CFG_W < HDR_W || CFG_W > CFG_MAX_W || NT < 1 ||
      ((CFG_W - HDR_W) % DW) != 0 || USED != IN_W) begin : g_bad_cfg
    $error("sop_unit: configuration length or operand bus width mismatch");
  end

  // Per-term values brought out for the checker.
  logic [NT_ARR-1:0][OUT_W-1:0] raw_val;
  logic [NT_ARR-1:0][OUT_W-1:0] term_val;
  logic [CNT_W-1:0]             bit_cnt;

  for (genvar k = 0; k < NT_ARR; k++) begin : g_term
    localparam int SA  = term_size_a(CFG_X, k);
    localparam int SB  = term_size_b(CFG_X, k);
    localparam int OFF = term_off(CFG_X, k);
    localparam int AW  = (SA > 0) ? SA : 1;
    localparam int BW  = (SB > 0) ? SB : 1;

    logic [AW-1:0] a_s;
    logic [BW-1:0] b_s;

    if (SA > 0) begin : g_a
      assign a_s = opnd_i[OFF +: AW];
    end else begin : g_a_none
      assign a_s = '0;
    end

    if (SB > 0) begin : g_b
      assign b_s = opnd_i[OFF + SA +: BW];
    end else begin : g_b_none
      assign b_s = '0;
    end

    sop_term #(
      .OUT_W    (OUT_W),
      .SA       (SA),
      .SB       (SB),
      .IS_SIGNED(term_signed(CFG_X, k)),
      .DO_SUB   (term_sub(CFG_X, k))
    ) u_term (
      .a_i   (a_s),
      .b_i   (b_s),
      .raw_o (raw_val[k]),
      .term_o(term_val[k])
    );
  end

  sop_bitcount #(.BIT_W(BIT_W), .CNT_W(CNT_W)) u_bits (
    .bits_i(bits_i),
    .cnt_o (bit_cnt)
  );

  sop_accum #(.NT(NT_ARR), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_acc (
    .term_i(term_val),
    .cnt_i (bit_cnt),
    .sum_o (result_o)
  );
endmodule

// File: rtl/sop_unit_chk.sv
module sop_unit_chk #(
  parameter int CFG_W = 54,
  parameter logic [CFG_W-1:0] CFG = '0,
  parameter int IN_W  = 39,
  parameter int BIT_W = 3,
  parameter int OUT_W = 12,
  parameter int NT    = 1,
  parameter int CNT_W = 2
) (
  input logic [IN_W-1:0]          opnd_i,
  input logic [BIT_W-1:0]         bits_i,
  input logic [OUT_W-1:0]         result_o,
  input logic [NT-1:0][OUT_W-1:0] raw_val,
  input logic [NT-1:0][OUT_W-1:0] term_val,
  input logic [CNT_W-1:0]         bit_cnt
);
  import sop_cfg_pkg::*;
  localparam cfg_vec_t CFG_X = cfg_vec_t'(CFG);

  always_comb begin
    // R6: the count of set single bits reaches the adder intact
    a_r6_bit_count: assert (32'(bit_cnt) == $countones(bits_i))
      else $error("bit count %0d for %b", bit_cnt, bits_i);

    // R7: zero in, zero out
    if (opnd_i == '0 && bits_i == '0) begin
      a_r7_zero_total: assert (result_o == '0)
        else $error("nonzero result %h for zero inputs", result_o);
    end

    for (int k = 0; k < NT; k++) begin
      logic [OUT_W-1:0] both;
      logic             fill_ok;
      int               sa;
      sa   = term_size_a(CFG_X, k);
      both = term_val[k] + raw_val[k];

      // R5: a subtracted term cancels its magnitude, an added one passes it on
      if (term_sub(CFG_X, k)) begin
        a_r5_sub_negates: assert (both == '0)
          else $error("term %0d not negated", k);
      end else begin
        a_r5_add_keeps: assert (term_val[k] == raw_val[k])
          else $error("term %0d altered", k);
      end

      // R8: an empty descriptor adds nothing
      if (sa == 0 && term_size_b(CFG_X, k) == 0) begin
        a_r8_empty_zero: assert (raw_val[k] == '0)
          else $error("empty term %0d is %h", k, raw_val[k]);
      end

      // R4: a single operand's upper bits follow its extension rule
      if (term_size_b(CFG_X, k) == 0 && sa > 0 && sa < OUT_W) begin
        fill_ok = 1'b1;
        for (int i = 0; i < OUT_W; i++)
          if (i >= sa && raw_val[k][i] !=
              (term_signed(CFG_X, k) ? raw_val[k][sa-1] : 1'b0))
            fill_ok = 1'b0;
        a_r4_single_fill: assert (fill_ok)
          else $error("term %0d bad extension %h", k, raw_val[k]);
      end
    end
  end
endmodule

bind sop_unit sop_unit_chk #(
  .CFG_W(CFG_W), .CFG(CFG), .IN_W(IN_W), .BIT_W(BIT_W),
  .OUT_W(OUT_W), .NT(NT_ARR), .CNT_W(CNT_W)
) u_chk (
  .opnd_i  (opnd_i),
  .bits_i  (bits_i),
  .result_o(result_o),
  .raw_val (raw_val),
  .term_val(term_val),
  .bit_cnt (bit_cnt)
);

// File: tb/tb_sop_unit.sv
module tb_sop_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  // Config A (defaults): N=4, 12-bit result
  //  t0 signed add 8x8, t1 unsigned sub 6x5, t2 signed sub 7 alone,
  //  t3 empty, t4 unsigned add 5 alone
  logic [38:0] op_a;
  logic [2:0]  bt_a;
  logic [11:0] res_a;
  sop_unit dut (.opnd_i(op_a), .bits_i(bt_a), .result_o(res_a));

  // Config B: N=3, 8-bit result
  //  t0 unsigned add 7x7, t1 signed add 4x3, t2 signed sub 3 alone
  logic [23:0] op_b;
  logic [1:0]  bt_b;
  logic [7:0]  res_b;
  sop_unit #(
    .CFG_W(28), .CFG({8'd15, 8'd113, 8'd252, 4'd3}),
    .IN_W(24), .BIT_W(2), .OUT_W(8)
  ) dut_b (.opnd_i(op_b), .bits_i(bt_b), .result_o(res_b));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic longint sx(longint v, int w);
    longint m = longint'(1) << (w - 1);
    return (v ^ m) - m;
  endfunction

  function automatic logic [11:0] ref_a(logic [38:0] op, logic [2:0] bt);
    longint a0 = sx(longint'(op[7:0]), 8);
    longint b0 = sx(longint'(op[15:8]), 8);
    longint a1 = longint'(op[21:16]);
    longint b1 = longint'(op[26:22]);
    longint a2 = sx(longint'(op[33:27]), 7);
    longint a4 = longint'(op[38:34]);
    longint r  = a0 * b0 - a1 * b1 - a2 + a4 + bt[0] + bt[1] + bt[2];
    return r[11:0];
  endfunction

  function automatic logic [7:0] ref_b(logic [23:0] op, logic [1:0] bt);
    longint a0 = longint'(op[6:0]);
    longint b0 = longint'(op[13:7]);
    longint a1 = sx(longint'(op[17:14]), 4);
    longint b1 = sx(longint'(op[20:18]), 3);
    longint a2 = sx(longint'(op[23:21]), 3);
    longint r  = a0 * b0 + a1 * b1 - a2 + bt[0] + bt[1];
    return r[7:0];
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_a(string tag, logic [38:0] op, logic [2:0] bt);
    @(negedge clk);
    op_a = op; bt_a = bt;
    #2;
    check(tag, 16'(res_a), 16'(ref_a(op, bt)));
  endtask

  task automatic run_b(string tag, logic [23:0] op, logic [1:0] bt);
    @(negedge clk);
    op_b = op; bt_b = bt;
    #2;
    check(tag, 16'(res_b), 16'(ref_b(op, bt)));
  endtask

  initial begin
    void'($urandom(32'd5150));
    op_a = '0; bt_a = '0; op_b = '0; bt_b = '0;
    #2;
    check("R7 zero inputs A", 16'(res_a), 16'h0);
    check("R7 zero inputs B", 16'(res_b), 16'h0);

    // R3 R5 R4: lone signed subtracted operand, -64 becomes +64
    run_a("R3 R4 R5 lone signed sub", 39'(7'h40) << 27, 3'b000);
    check("R3 lone sub value", 16'(res_a), 16'd64);
    // R4: unsigned lone operand top bit set stays positive
    run_a("R4 unsigned lone top bit", 39'(5'h10) << 34, 3'b000);
    check("R4 unsigned lone value", 16'(res_a), 16'd16);
    // R4: signed product of -128 * 1
    run_a("R4 signed product", {23'd0, 8'd1, 8'h80}, 3'b000);
    check("R4 signed product value", 16'(res_a), 16'hF80);
    // R5: unsigned subtracted product 63*31
    run_a("R5 unsigned sub product", 39'({5'h1F, 6'h3F}) << 16, 3'b000);
    // R6: single bits alone
    run_a("R6 bits only A", '0, 3'b111);
    check("R6 bits only value", 16'(res_a), 16'd3);
    run_b("R6 bits only B", '0, 2'b10);
    // R7: overflow of signed 8x8 and mixed all-ones
    run_a("R7 overflow -128*-128", {23'd0, 8'h80, 8'h80}, 3'b000);
    check("R7 wrap value", 16'(res_a), 16'h000);
    run_a("R7 all ones A", '1, 3'b111);
    run_b("R7 all ones B", '1, 2'b11);
    // R1 R2: config B layout, unsigned 127*127 wraps in 8 bits
    run_b("R1 R2 unsigned product B", 24'h3FFF, 2'b00);
    check("R1 product value", 16'(res_b), 16'(8'((127 * 127) & 255)));
    // R1 R2: signed 4x3 slice just above the first pair
    run_b("R1 R2 signed pair B", 24'(7'b100_1000) << 14, 2'b00);
    // R8: empty descriptor between two lone terms takes no bus bits
    run_a("R8 empty descriptor", {5'h1F, 7'h01, 27'd0}, 3'b001);
    check("R8 value", 16'(res_a), 16'(12'(31 - 1 + 1)));

    for (int i = 0; i < 400; i++)
      run_a("R2 R7 random A", {$urandom, $urandom}, 3'($urandom));
    for (int i = 0; i < 400; i++)
      run_b("R1 R2 random B", 24'($urandom), 2'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule